// File: doc/BRIEF.md
# Floating-Point Compare Unit

This block compares two single-precision IEEE-754 operands inside a processor pipeline and returns a 32-bit result holding 0 or 1. A 3-bit operation code picks one of seven predicates. Each predicate tests operand B against operand A, so "less" means B < A. Along with the result it keeps two sticky status flags, invalid-operation and denormal-operand. When a trap is taken it also raises an exception strobe with a 5-bit cause code.

Operands are classified before they are ordered. A denormal operand is refused and not compared. Each predicate then has its own rule for quiet and signaling NaNs, including whether the NaN raises invalid-operation. An exception-enable input decides what a raised condition does. It either becomes a trap that blocks the destination write, or it only sets the sticky flags while the result is still written. The parameter `AREA_OPT` selects the timing. With `AREA_OPT` = 0 the unit has a one-cycle latency. With `AREA_OPT` = 1 it adds a register after classification and has a two-cycle latency.

Top module: `fp_cmp_unit`

## Requirements
- R1: On ordered operands the codes give these results, where gt means B > A, lt means B < A and eq means B = A: 3'b001 gives lt, 3'b010 gives eq, 3'b011 gives lt or eq, 3'b100 gives gt, 3'b101 gives not eq, 3'b110 gives gt or eq, and 3'b000 gives 0.
- R2: +0 and -0 compare equal. Infinities (exponent 255, fraction 0) order beyond every finite value. When both operands are negative, the larger magnitude is the smaller value.
- R3: A NaN has exponent 255 and a nonzero fraction. It is quiet when fraction bit 22 is 1 and signaling when that bit is 0. Under code 3'b000, any NaN gives result 1. A quiet NaN raises nothing; a signaling NaN raises invalid-operation.
- R4: Under codes 3'b001, 3'b011, 3'b100 and 3'b110, any NaN, quiet or signaling, gives result 0 and raises invalid-operation.
- R5: Under code 3'b010 a NaN gives 0, and under 3'b101 a NaN gives 1. In both cases a quiet NaN raises nothing and a signaling NaN raises invalid-operation.
- R6: A denormal operand has exponent 0 and a nonzero fraction. It gives result 0 and raises denormal-operand only. This check overrides every NaN and ordering rule, so invalid-operation is not raised in the same operation.
- R7: Code 3'b111 is reserved. It gives result 0 and raises nothing, whatever the operands are.
- R8: If `exc_en` is 1 and a condition is raised, `res_wr` is 0, `exc_strobe` is 1 and `exc_cause` is 5'b00110. If `exc_en` is 0, the result is written with `res_wr` = 1 and there is no strobe. In both cases the sticky flags are set.
- R9: All outputs are 0 after reset. `flag_invalid` and `flag_denorm` stay set until the next reset.
- R10: `res_valid` pulses exactly 1 + `AREA_OPT` cycles after each `in_valid` cycle. Operations may be issued on back-to-back cycles.
- R11: Bits 31:1 of `res_data` are always 0. `exc_cause` is 0 when no trap is taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operation issued this cycle |
| op_a | input | 32 | Operand A (single precision) |
| op_b | input | 32 | Operand B (single precision) |
| op_sel | input | 3 | Predicate code |
| exc_en | input | 1 | Turns raised conditions into traps |
| res_valid | output | 1 | Result cycle for an issued operation |
| res_wr | output | 1 | Destination write enable |
| res_data | output | 32 | Comparison result, 0 or 1 |
| exc_strobe | output | 1 | Trap taken for this operation |
| exc_cause | output | 5 | Cause code while a trap is taken |
| flag_invalid | output | 1 | Sticky invalid-operation flag |
| flag_denorm | output | 1 | Sticky denormal-operand flag |

## Verification
Two pairs of functions can meet in one operation or one cycle. First, the denormal check and the NaN rules collide when one operand is denormal and the other is a signaling NaN. The bench issues that pair under several codes and expects denormal-operand alone, with result 0. Second, a trap and an ordinary write can follow each other on consecutive result cycles. Back-to-back issue of a trapping operation and then a normal one covers this case. The bench checks that the write enable drops only for the first and that the sticky flag raised by the first is still set when the second completes.

// File: rtl/fpcmp_pkg.sv
package fpcmp_pkg;
  localparam int FP_W    = 32;
  localparam int EXP_W   = 8;
  localparam int FRAC_W  = 23;
  localparam int MAG_W   = FP_W - 1;
  localparam int CAUSE_W = 5;
  localparam logic [CAUSE_W-1:0] CAUSE_FP = 5'b00110;

  typedef enum logic [2:0] {
    OP_UNORD = 3'd0,
    OP_LT    = 3'd1,
    OP_EQ    = 3'd2,
    OP_LE    = 3'd3,
    OP_GT    = 3'd4,
    OP_NE    = 3'd5,
    OP_GE    = 3'd6,
    OP_RSVD  = 3'd7
  } cmp_op_e;

  typedef struct packed {
    logic             sign;
    logic             is_zero;
    logic             is_denorm;
    logic             is_nan;
    logic             is_snan;
    logic [MAG_W-1:0] mag;
  } fp_class_t;

  typedef struct packed {
    logic gt;
    logic lt;
    logic eq;
  } fp_order_t;

  function automatic fp_class_t classify(input logic [FP_W-1:0] v);
    fp_class_t c;
    logic [EXP_W-1:0]  e;
    logic [FRAC_W-1:0] f;
    e = v[FP_W-2 -: EXP_W];
    f = v[FRAC_W-1:0];
    c.sign      = v[FP_W-1];
    c.mag       = v[MAG_W-1:0];
    c.is_zero   = (e == '0) && (f == '0);
    c.is_denorm = (e == '0) && (f != '0);
    c.is_nan    = (e == '1) && (f != '0);
    c.is_snan   = c.is_nan && !f[FRAC_W-1];
    return c;
  endfunction

  // Relation of B to A for non-NaN, non-denormal operands.
  function automatic fp_order_t order_b_vs_a(input fp_class_t a, input fp_class_t b);
    fp_order_t o;
    o = '0;
    if (a.is_zero && b.is_zero) begin
      o.eq = 1'b1;
    end else if (a.sign != b.sign) begin
      o.lt = b.sign;
      o.gt = a.sign;
    end else if (a.mag == b.mag) begin
      o.eq = 1'b1;
    end else begin
      o.lt = (b.mag < a.mag) ^ a.sign;
      o.gt = !o.lt;
    end
    return o;
  endfunction
endpackage

// File: rtl/fpcmp_classify.sv
module fpcmp_classify
  import fpcmp_pkg::*;
(
  input  logic [FP_W-1:0] opnd,
  output fp_class_t       cls
);
  assign cls = classify(opnd);
endmodule

// File: rtl/fpcmp_order.sv
module fpcmp_order
  import fpcmp_pkg::*;
(
  input  fp_class_t cls_a,
  input  fp_class_t cls_b,
  output fp_order_t rel
);
  assign rel = order_b_vs_a(cls_a, cls_b);
endmodule

// File: rtl/fpcmp_decide.sv
module fpcmp_decide
  import fpcmp_pkg::*;
(
  input  logic [2:0] op,
  input  fp_class_t  cls_a,
  input  fp_class_t  cls_b,
  input  fp_order_t  rel,
  output logic       result,
  output logic       inv_hit,
  output logic       den_hit
);
  logic any_nan, any_snan, any_den;

  assign any_nan  = cls_a.is_nan    | cls_b.is_nan;
  assign any_snan = cls_a.is_snan   | cls_b.is_snan;
  assign any_den  = cls_a.is_denorm | cls_b.is_denorm;

  always_comb begin
    result  = 1'b0;
    inv_hit = 1'b0;
    den_hit = 1'b0;
    if (cmp_op_e'(op) == OP_RSVD) begin
      result = 1'b0;
    end else if (any_den) begin
      den_hit = 1'b1;
    end else if (any_nan) begin
      case (cmp_op_e'(op))
        OP_UNORD: begin result = 1'b1; inv_hit = any_snan; end
        OP_EQ:    begin result = 1'b0; inv_hit = any_snan; end
        OP_NE:    begin result = 1'b1; inv_hit = any_snan; end
        default:  begin result = 1'b0; inv_hit = 1'b1;     end
      endcase
    end else begin
      case (cmp_op_e'(op))
        OP_LT:   result = rel.lt;
        OP_EQ:   result = rel.eq;
        OP_LE:   result = rel.lt | rel.eq;
        OP_GT:   result = rel.gt;
        OP_NE:   result = !rel.eq;
        OP_GE:   result = rel.gt | rel.eq;
        default: result = 1'b0;
      endcase
    end
  end
endmodule

// File: rtl/fp_cmp_unit.sv
module fp_cmp_unit
  import fpcmp_pkg::*;
#(
  parameter int AREA_OPT = 0,
  parameter int RES_W    = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               in_valid,
  input  logic [FP_W-1:0]    op_a,
  input  logic [FP_W-1:0]    op_b,
  input  logic [2:0]         op_sel,
  input  logic               exc_en,
  output logic               res_valid,
  output logic               res_wr,
  output logic [RES_W-1:0]   res_data,
  output logic               exc_strobe,
  output logic [CAUSE_W-1:0] exc_cause,
  output logic               flag_invalid,
  output logic               flag_denorm
);
  localparam int N_OPND = 2;

  logic [FP_W-1:0] opnd_in [N_OPND];
  fp_class_t       cls_in  [N_OPND];

  assign opnd_in[0] = op_a;
  assign opnd_in[1] = op_b;

  for (genvar gi = 0; gi < N_OPND; gi++) begin : g_cls
    fpcmp_classify u_cls (.opnd(opnd_in[gi]), .cls(cls_in[gi]));
  end

  // Stage boundary: either a register (area mode) or a wire (fast mode).
  logic       s_valid, s_en;
  logic [2:0] s_op;
  fp_class_t  s_ca, s_cb;

  if (AREA_OPT != 0) begin : g_area
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        s_valid <= 1'b0;
        s_en    <= 1'b0;
        s_op    <= '0;
        s_ca    <= '0;
        s_cb    <= '0;
      end else begin
        s_valid <= in_valid;
        s_en    <= exc_en;
        s_op    <= op_sel;
        s_ca    <= cls_in[0];
        s_cb    <= cls_in[1];
      end
    end
    a_r10_latency: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> ##1 res_valid);
  end else begin : g_fast
    assign s_valid = in_valid;
    assign s_en    = exc_en;
    assign s_op    = op_sel;
    assign s_ca    = cls_in[0];
    assign s_cb    = cls_in[1];
    a_r10_latency: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> res_valid);
  end

  fp_order_t rel;
  logic      cmp_res, inv_hit, den_hit;

  fpcmp_order u_ord (.cls_a(s_ca), .cls_b(s_cb), .rel(rel));

  fpcmp_decide u_dec (
    .op(s_op), .cls_a(s_ca), .cls_b(s_cb), .rel(rel),
    .result(cmp_res), .inv_hit(inv_hit), .den_hit(den_hit)
  );

  // Named internal events.
  logic cond_raise, trap_take;
  assign cond_raise = s_valid && (inv_hit || den_hit);
  assign trap_take  = cond_raise && s_en;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      res_valid    <= 1'b0;
      res_wr       <= 1'b0;
      res_data     <= '0;
      exc_strobe   <= 1'b0;
      exc_cause    <= '0;
      flag_invalid <= 1'b0;
      flag_denorm  <= 1'b0;
    end else begin
      res_valid    <= s_valid;
      res_wr       <= s_valid && !trap_take;
      res_data     <= s_valid ? RES_W'(cmp_res) : '0;
      exc_strobe   <= trap_take;
      exc_cause    <= trap_take ? CAUSE_FP : '0;
      flag_invalid <= flag_invalid | (s_valid & inv_hit);
      flag_denorm  <= flag_denorm  | (s_valid & den_hit);
    end
  end

  a_r8_trap_blocks_write: assert property (@(posedge clk) disable iff (!rst_n)
    exc_strobe |-> (res_valid && !res_wr));
  a_r8_trap_cause: assert property (@(posedge clk) disable iff (!rst_n)
    exc_strobe |-> (exc_cause == CAUSE_FP));
  a_r9_invalid_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    flag_invalid |=> flag_invalid);
  a_r9_denorm_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    flag_denorm |=> flag_denorm);
  a_r11_result_bit: assert property (@(posedge clk) disable iff (!rst_n)
    res_data[RES_W-1:1] == '0);
  a_r11_cause_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !exc_strobe |-> (exc_cause == '0));
  a_r6_denorm_first: assert property (@(posedge clk) disable iff (!rst_n)
    (s_valid && den_hit) |-> (!inv_hit && !cmp_res));
  a_r7_reserved_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (s_valid && s_op == 3'd7) |-> (!cmp_res && !inv_hit && !den_hit));
  a_r1_order_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    (s_valid && !s_ca.is_nan && !s_cb.is_nan && !s_ca.is_denorm && !s_cb.is_denorm)
      |-> ($countones({rel.gt, rel.lt, rel.eq}) == 1));
endmodule

// File: tb/fp_cmp_unit_bench.sv
module fp_cmp_unit_bench;
  localparam int CLK_PERIOD = 10;
  localparam int AREA       = 1;
  localparam int LAT        = 1 + AREA;

  localparam logic [31:0] P1   = 32'h3F800000, P2   = 32'h40000000;
  localparam logic [31:0] N1   = 32'hBF800000, N2   = 32'hC0000000;
  localparam logic [31:0] PZ   = 32'h00000000, NZ   = 32'h80000000;
  localparam logic [31:0] PINF = 32'h7F800000, NINF = 32'hFF800000;
  localparam logic [31:0] PMAX = 32'h7F7FFFFF;
  localparam logic [31:0] QNAN = 32'h7FC00000, QNEG = 32'hFFC00001;
  localparam logic [31:0] SNAN = 32'h7F800001, SNEG = 32'hFFA00000;
  localparam logic [31:0] DEN  = 32'h00000001, DNEG = 32'h80400000;

  logic        clk = 1'b0, rst_n = 1'b0, in_valid = 1'b0, exc_en = 1'b0;
  logic [31:0] op_a = '0, op_b = '0;
  logic [2:0]  op_sel = '0;
  logic        res_valid, res_wr, exc_strobe, flag_invalid, flag_denorm;
  logic [31:0] res_data;
  logic [4:0]  exc_cause;

  int n_checks = 0, n_fail = 0;
  logic mdl_inv = 1'b0, mdl_den = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  fp_cmp_unit #(.AREA_OPT(AREA)) u_fp_cmp_unit (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op_a(op_a), .op_b(op_b),
    .op_sel(op_sel), .exc_en(exc_en), .res_valid(res_valid), .res_wr(res_wr),
    .res_data(res_data), .exc_strobe(exc_strobe), .exc_cause(exc_cause),
    .flag_invalid(flag_invalid), .flag_denorm(flag_denorm)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Independent reference: operands mapped to signed keys.
  function automatic logic [2:0] ref_cmp(input logic [2:0] op, input logic [31:0] a,
                                         input logic [31:0] b);
    logic an, bn, sn, r, inv;
    longint ka, kb;
    if (op == 3'd7) return 3'b000;
    if ((a[30:23] == 0 && a[22:0] != 0) || (b[30:23] == 0 && b[22:0] != 0)) return 3'b001;
    an = (a[30:23] == 8'hFF) && (a[22:0] != 0);
    bn = (b[30:23] == 8'hFF) && (b[22:0] != 0);
    if (an || bn) begin
      sn = (an && !a[22]) || (bn && !b[22]);
      case (op)
        3'd0: begin r = 1; inv = sn; end
        3'd2: begin r = 0; inv = sn; end
        3'd5: begin r = 1; inv = sn; end
        default: begin r = 0; inv = 1; end
      endcase
      return {r, inv, 1'b0};
    end
    ka = a[31] ? -longint'(a[30:0]) : longint'(a[30:0]);
    kb = b[31] ? -longint'(b[30:0]) : longint'(b[30:0]);
    case (op)
      3'd1: r = kb < ka;
      3'd2: r = kb == ka;
      3'd3: r = kb <= ka;
      3'd4: r = kb > ka;
      3'd5: r = kb != ka;
      3'd6: r = kb >= ka;
      default: r = 0;
    endcase
    return {r, 2'b00};
  endfunction

  task automatic drive(input logic [2:0] op, input logic [31:0] a, input logic [31:0] b,
                       input logic en);
    in_valid = 1'b1; op_sel = op; op_a = a; op_b = b; exc_en = en;
  endtask

  task automatic check_out(input string tag, input logic [2:0] op, input logic [31:0] a,
                           input logic [31:0] b, input logic en);
    logic [2:0] e;
    logic trap;
    e = ref_cmp(op, a, b);
    trap = en && (e[1] || e[0]);
    mdl_inv |= e[1];
    mdl_den |= e[0];
    chk({tag, " R10 valid"}, 32'(res_valid), 32'd1);
    chk({tag, " R8 wr"}, 32'(res_wr), 32'(!trap));
    chk({tag, " R11 data"}, res_data, 32'(e[2]));
    chk({tag, " R8 strobe"}, 32'(exc_strobe), 32'(trap));
    chk({tag, " R11 cause"}, 32'(exc_cause), trap ? 32'h6 : 32'h0);
    chk({tag, " R9 inv flag"}, 32'(flag_invalid), 32'(mdl_inv));
    chk({tag, " R9 den flag"}, 32'(flag_denorm), 32'(mdl_den));
  endtask

  task automatic run_op(input string tag, input logic [2:0] op, input logic [31:0] a,
                        input logic [31:0] b, input logic en);
    drive(op, a, b, en);
    @(negedge clk);
    in_valid = 1'b0;
    for (int i = 1; i < LAT; i++) begin
      chk({tag, " R10 early"}, 32'(res_valid), 32'd0);
      @(negedge clk);
    end
    check_out(tag, op, a, b, en);
  endtask

  task automatic do_reset();
    rst_n = 1'b0; in_valid = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    mdl_inv = 1'b0; mdl_den = 1'b0;
    @(negedge clk);
  endtask

  task automatic t_reset();
    do_reset();
    chk("R9 reset valid", 32'(res_valid), 0);
    chk("R9 reset wr", 32'(res_wr), 0);
    chk("R9 reset data", res_data, 0);
    chk("R9 reset strobe", 32'(exc_strobe), 0);
    chk("R9 reset flags", {30'd0, flag_invalid, flag_denorm}, 0);
  endtask

  task automatic t_ordered();
    logic [31:0] av [6] = '{P1, P2, N1, N2, PMAX, P1};
    logic [31:0] bv [6] = '{P2, P1, N2, N1, PINF, P1};
    for (int k = 0; k < 6; k++)
      for (int op = 0; op < 7; op++)
        run_op("R1 ordered", 3'(op), av[k], bv[k], 1'b1);
  endtask

  task automatic t_signed_zero_inf();
    for (int op = 1; op < 7; op++) begin
      run_op("R2 zeros", 3'(op), PZ, NZ, 1'b0);
      run_op("R2 neg inf", 3'(op), N2, NINF, 1'b0);
      run_op("R2 neg mag", 3'(op), N1, N2, 1'b0);
      run_op("R2 mixed sign", 3'(op), NZ, P1, 1'b0);
    end
  endtask

  task automatic t_unordered();
    run_op("R3 ordered", 3'd0, P1, N2, 1'b0);
    run_op("R3 qnan", 3'd0, QNAN, P1, 1'b0);
    run_op("R3 qnan neg", 3'd0, P1, QNEG, 1'b1);
    run_op("R3 snan", 3'd0, P1, SNAN, 1'b0);
  endtask

  task automatic t_relational_nan();
    logic [2:0] ops [4] = '{3'd1, 3'd3, 3'd4, 3'd6};
    do_reset();
    for (int k = 0; k < 4; k++) begin
      run_op("R4 qnan", ops[k], QNAN, P2, 1'b0);
      run_op("R4 snan", ops[k], P2, SNEG, 1'b0);
    end
  endtask

  task automatic t_eq_ne();
    do_reset();
    run_op("R5 eq qnan", 3'd2, QNAN, QNAN, 1'b1);
    run_op("R5 ne qnan", 3'd5, P1, QNEG, 1'b1);
    run_op("R5 eq snan", 3'd2, SNAN, P1, 1'b0);
    run_op("R5 ne snan", 3'd5, P1, SNAN, 1'b0);
  endtask

  task automatic t_denorm();
    do_reset();
    run_op("R6 den a", 3'd5, DEN, P1, 1'b0);
    run_op("R6 den b", 3'd0, P1, DNEG, 1'b0);
    // Denormal together with a signaling NaN: denormal wins, no invalid.
    for (int op = 0; op < 7; op++)
      run_op("R6 den+snan", 3'(op), SNAN, DEN, 1'b0);
    chk("R6 no invalid", 32'(flag_invalid), 32'd0);
  endtask

  task automatic t_reserved();
    do_reset();
    run_op("R7 rsvd nan", 3'd7, SNAN, QNAN, 1'b1);
    run_op("R7 rsvd den", 3'd7, DEN, P1, 1'b1);
    run_op("R7 rsvd equal", 3'd7, P1, P1, 1'b1);
  endtask

  task automatic t_trap();
    do_reset();
    run_op("R8 trap snan", 3'd1, SNAN, P1, 1'b1);
    run_op("R8 trap den", 3'd2, P1, DEN, 1'b1);
    run_op("R8 no trap qnan", 3'd2, QNAN, P1, 1'b1);
    run_op("R8 masked", 3'd4, QNAN, P1, 1'b0);
  endtask

  task automatic t_back_to_back();
    do_reset();
    drive(3'd6, P1, SNAN, 1'b1);
    @(negedge clk);
    drive(3'd4, P1, P2, 1'b1);
    @(negedge clk);
    in_valid = 1'b0;
    for (int i = 2; i < LAT; i++) @(negedge clk);
    check_out("R10 b2b first", 3'd6, P1, SNAN, 1'b1);
    @(negedge clk);
    check_out("R10 b2b second", 3'd4, P1, P2, 1'b1);
    @(negedge clk);
    chk("R10 b2b idle", 32'(res_valid), 32'd0);
    chk("R9 b2b sticky", 32'(flag_invalid), 32'd1);
  endtask

  task automatic t_sticky_clear();
    do_reset();
    chk("R9 cleared inv", 32'(flag_invalid), 32'd0);
    chk("R9 cleared den", 32'(flag_denorm), 32'd0);
    run_op("R9 after clear", 3'd3, P1, N1, 1'b0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  end

  initial begin
    t_reset();
    t_ordered();
    t_signed_zero_inf();
    t_unordered();
    t_relational_nan();
    t_eq_ne();
    t_denorm();
    t_reserved();
    t_trap();
    t_back_to_back();
    t_sticky_clear();
    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  end
endmodule